// File: doc/BRIEF.md
# Half-Precision Register Transfer Unit

This block takes one 32-bit instruction word and moves a 16-bit half-precision value between two register files that it holds inside: sixteen 32-bit general-purpose registers and thirty-two 32-bit floating-point registers. A direction bit picks which file is the source. Only the low half of the source moves. The destination gets that half in its low 16 bits and zeros in its upper 16 bits. The word can arrive in either of two encodings. An encoding select input says which one is in use: a conditional form, whose top nibble is a condition field, or a fixed form, whose top nibble must be 1110.

Alongside the word the caller supplies several flags: the result of the condition check, whether half-precision support is present, whether floating-point access is allowed, and whether the instruction sits inside an if-then block. The unit decodes the fields and judges whether the instruction is legal. It reports anything it does not accept through a set of flags. When an instruction is legal and allowed to run, it writes the destination on the clock edge that samples the strobe. A done pulse follows on the next edge, and the flags for that instruction are valid while done is high. Seed ports let a caller load either file, and peek ports read either file combinationally.

Top module: `hp_xfer_unit`

## Requirements
- R1: An instruction is recognised only if all of the following hold: bits 27:21 equal 1110000, bits 11:8 equal 1001, and bit 4 is 1. In addition, with enc_sel=0 bits 31:28 must not be 1111, and with enc_sel=1 bits 31:28 must equal 1110. An unrecognised word raises flag_nomatch, clears every other flag and writes nothing.
- R2: With bit 20 at 0 the move goes from the general-purpose register at index bits 15:12 to the floating-point register at index {bits 19:16, bit 7}, where bit 7 is the least significant bit. With bit 20 at 1 the move goes the other way between the same two registers.
- R3: The destination receives 16 zero bits above the low 16 bits of the source.
- R4: With fp16_en low, flag_undef rises and nothing is written.
- R5: A general-purpose index of 15 raises flag_unpred_rt and nothing is written. Index 13 transfers normally.
- R6: flag_cu rises when, with enc_sel=0, bits 31:28 are not 1110, or when, with enc_sel=1, in_it is high.
- R7: The parameter CU_POLICY sets what happens when flag_cu is raised: 0 marks the instruction undefined, 1 runs it as if the condition passed, 2 runs nothing. The default is 2, under which the instruction writes nothing and leaves flag_undef clear unless R4 applies.
- R8: A recognised instruction that is not ambiguous writes only when cond_pass and fp_en are both high.
- R9: If any of bits 6:5 or 3:0 is nonzero, flag_sbz rises and the transfer still takes place.
- R10: A write happens on the edge that samples instr_valid. done is high for exactly one cycle after the following edge. executed and the flags are valid while done is high, and executed is 1 exactly when a write took place.
- R11: Reset clears done, every flag and every register in both files.
- R12: A seed load writes its file on the next edge. The peek ports show file contents combinationally. If a seed and a transfer target the same register on the same edge, the transfer wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe, one cycle |
| instr_word | input | 32 | Instruction word |
| enc_sel | input | 1 | 0 conditional encoding, 1 fixed encoding |
| cond_pass | input | 1 | Condition check result |
| fp16_en | input | 1 | Half-precision support present |
| fp_en | input | 1 | Floating-point access allowed |
| in_it | input | 1 | Instruction sits in an if-then block |
| gpr_ld_en | input | 1 | Seed write enable, general-purpose file |
| gpr_ld_idx | input | 4 | Seed index, general-purpose file |
| gpr_ld_data | input | 32 | Seed data, general-purpose file |
| fpr_ld_en | input | 1 | Seed write enable, floating-point file |
| fpr_ld_idx | input | 5 | Seed index, floating-point file |
| fpr_ld_data | input | 32 | Seed data, floating-point file |
| gpr_pk_idx | input | 4 | Peek index, general-purpose file |
| gpr_pk_data | output | 32 | Peek data, general-purpose file |
| fpr_pk_idx | input | 5 | Peek index, floating-point file |
| fpr_pk_data | output | 32 | Peek data, floating-point file |
| done | output | 1 | Completion pulse |
| executed | output | 1 | A write took place |
| flag_undef | output | 1 | Undefined instruction |
| flag_unpred_rt | output | 1 | General-purpose index was 15 |
| flag_cu | output | 1 | Ambiguous condition context |
| flag_sbz | output | 1 | Reserved bits nonzero |
| flag_nomatch | output | 1 | Word is not this instruction |

## Verification
Each transfer writes its destination register on the edge that samples the strobe, and done, executed and the flags appear one edge after that. The driver therefore queues an expected record when it issues a word, then holds off the next word for three falling edges. The monitor acts on the falling edge at which done is high. At that point it pops the record, compares the flags, and peeks the destination register. Because no later transfer has reached the file yet, a required write and a required absence of any write can both be told apart at that moment.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int GPR_N  = 16;
    localparam int FPR_N  = 32;
    localparam int GIDX_W = $clog2(GPR_N);
    localparam int FIDX_W = $clog2(FPR_N);

    typedef enum logic [1:0] {
        CU_AS_UNDEF = 2'd0,
        CU_AS_PASS  = 2'd1,
        CU_AS_NOP   = 2'd2
    } cu_pol_e;

    typedef enum logic {
        ENC_COND  = 1'b0,
        ENC_FIXED = 1'b1
    } enc_e;

    typedef struct packed {
        logic              match;
        logic              to_gpr;
        logic [GIDX_W-1:0] rt;
        logic [FIDX_W-1:0] fidx;
        logic              cond_al;
        logic              sbz_bad;
        logic              rt_pc;
    } dec_t;

    typedef struct packed {
        logic nomatch;
        logic undef;
        logic unpred_rt;
        logic cu;
        logic sbz;
        logic executed;
    } flags_t;

    function automatic logic [WORD_W-1:0] zext_half(input logic [HALF_W-1:0] v);
        return {{(WORD_W-HALF_W){1'b0}}, v};
    endfunction

    function automatic logic body_ok(input logic [WORD_W-1:0] w);
        return (w[27:21] == 7'b1110000) && (w[11:8] == 4'b1001) && w[4];
    endfunction

endpackage

// File: rtl/hpx_decode.sv
module hpx_decode
    import hpx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              enc_sel,
    output dec_t              dec
);
    logic [3:0] top;
    logic       top_ok;

    assign top = word[31:28];

    always_comb begin
        if (enc_sel == ENC_FIXED) top_ok = (top == 4'hE);
        else                      top_ok = (top != 4'hF);
    end

    always_comb begin
        dec.match   = body_ok(word) && top_ok;
        dec.to_gpr  = word[20];
        dec.rt      = word[15:12];
        dec.fidx    = {word[19:16], word[7]};
        dec.cond_al = (top == 4'hE);
        dec.sbz_bad = (word[6:5] != 2'b00) || (word[3:0] != 4'h0);
        dec.rt_pc   = (word[15:12] == 4'hF);
    end
endmodule

// File: rtl/hpx_regfile.sv
module hpx_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int RD_W  = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    wi,
    input  logic [WIDTH-1:0] wd,
    input  logic             ld_en,
    input  logic [IW-1:0]    ld_i,
    input  logic [WIDTH-1:0] ld_d,
    input  logic [IW-1:0]    ra,
    output logic [RD_W-1:0]  rd,
    input  logic [IW-1:0]    pa,
    output logic [WIDTH-1:0] pd
);
    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                             mem[g] <= '0;
            else if (we && wi == IW'(g))         mem[g] <= wd;
            else if (ld_en && ld_i == IW'(g))    mem[g] <= ld_d;
        end
    end

    logic [WIDTH-1:0] ra_word;
    assign ra_word = mem[ra];
    assign rd      = ra_word[RD_W-1:0];
    assign pd      = mem[pa];

    logic unused_hi;
    assign unused_hi = ^ra_word[WIDTH-1:RD_W];
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
    import hpx_pkg::*;
#(
    parameter cu_pol_e CU_POLICY = CU_AS_NOP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  dec_t              dec,
    input  logic              enc_sel,
    input  logic              cond_pass,
    input  logic              fp16_en,
    input  logic              fp_en,
    input  logic              in_it,
    input  logic [HALF_W-1:0] gpr_src,
    input  logic [HALF_W-1:0] fpr_src,
    output logic              gpr_we,
    output logic [GIDX_W-1:0] gpr_wi,
    output logic [WORD_W-1:0] gpr_wd,
    output logic              fpr_we,
    output logic [FIDX_W-1:0] fpr_wi,
    output logic [WORD_W-1:0] fpr_wd,
    output logic              done,
    output flags_t            flags
);
    logic   cu_hit, undef_now, pass_now, go;
    flags_t now_f, s1_f;
    logic   s1_v;

    always_comb begin
        cu_hit    = (enc_sel == ENC_COND) ? !dec.cond_al : in_it;
        undef_now = !fp16_en || (cu_hit && CU_POLICY == CU_AS_UNDEF);
        pass_now  = cu_hit ? (CU_POLICY == CU_AS_PASS) : cond_pass;
        go        = valid && dec.match && !undef_now && !dec.rt_pc
                    && pass_now && fp_en;
    end

    always_comb begin
        now_f = '0;
        if (!dec.match) begin
            now_f.nomatch = 1'b1;
        end else begin
            now_f.undef     = undef_now;
            now_f.unpred_rt = dec.rt_pc;
            now_f.cu        = cu_hit;
            now_f.sbz       = dec.sbz_bad;
            now_f.executed  = go;
        end
    end

    assign gpr_we = go && dec.to_gpr;
    assign fpr_we = go && !dec.to_gpr;
    assign gpr_wi = dec.rt;
    assign fpr_wi = dec.fidx;
    assign gpr_wd = zext_half(fpr_src);
    assign fpr_wd = zext_half(gpr_src);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v  <= 1'b0;
            s1_f  <= '0;
            done  <= 1'b0;
            flags <= '0;
        end else begin
            s1_v  <= valid;
            s1_f  <= valid ? now_f : '0;
            done  <= s1_v;
            flags <= s1_v ? s1_f : '0;
        end
    end
endmodule

// File: rtl/hp_xfer_unit.sv
module hp_xfer_unit
    import hpx_pkg::*;
#(
    parameter cu_pol_e CU_POLICY = CU_AS_NOP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              enc_sel,
    input  logic              cond_pass,
    input  logic              fp16_en,
    input  logic              fp_en,
    input  logic              in_it,
    input  logic              gpr_ld_en,
    input  logic [GIDX_W-1:0] gpr_ld_idx,
    input  logic [WORD_W-1:0] gpr_ld_data,
    input  logic              fpr_ld_en,
    input  logic [FIDX_W-1:0] fpr_ld_idx,
    input  logic [WORD_W-1:0] fpr_ld_data,
    input  logic [GIDX_W-1:0] gpr_pk_idx,
    output logic [WORD_W-1:0] gpr_pk_data,
    input  logic [FIDX_W-1:0] fpr_pk_idx,
    output logic [WORD_W-1:0] fpr_pk_data,
    output logic              done,
    output logic              executed,
    output logic              flag_undef,
    output logic              flag_unpred_rt,
    output logic              flag_cu,
    output logic              flag_sbz,
    output logic              flag_nomatch
);
    dec_t              dec;
    flags_t            fl;
    logic [HALF_W-1:0] gpr_src, fpr_src;
    logic              x_gpr_we, x_fpr_we;
    logic [GIDX_W-1:0] x_gpr_wi;
    logic [FIDX_W-1:0] x_fpr_wi;
    logic [WORD_W-1:0] x_gpr_wd, x_fpr_wd;

    hpx_decode u_dec (
        .word    (instr_word),
        .enc_sel (enc_sel),
        .dec     (dec)
    );

    hpx_regfile #(.DEPTH(GPR_N), .WIDTH(WORD_W), .RD_W(HALF_W)) u_gpr (
        .clk (clk), .rst (rst),
        .we  (x_gpr_we), .wi (x_gpr_wi), .wd (x_gpr_wd),
        .ld_en (gpr_ld_en), .ld_i (gpr_ld_idx), .ld_d (gpr_ld_data),
        .ra  (dec.rt), .rd (gpr_src),
        .pa  (gpr_pk_idx), .pd (gpr_pk_data)
    );

    hpx_regfile #(.DEPTH(FPR_N), .WIDTH(WORD_W), .RD_W(HALF_W)) u_fpr (
        .clk (clk), .rst (rst),
        .we  (x_fpr_we), .wi (x_fpr_wi), .wd (x_fpr_wd),
        .ld_en (fpr_ld_en), .ld_i (fpr_ld_idx), .ld_d (fpr_ld_data),
        .ra  (dec.fidx), .rd (fpr_src),
        .pa  (fpr_pk_idx), .pd (fpr_pk_data)
    );

    hpx_ctrl #(.CU_POLICY(CU_POLICY)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .valid     (instr_valid),
        .dec       (dec),
        .enc_sel   (enc_sel),
        .cond_pass (cond_pass),
        .fp16_en   (fp16_en),
        .fp_en     (fp_en),
        .in_it     (in_it),
        .gpr_src   (gpr_src),
        .fpr_src   (fpr_src),
        .gpr_we    (x_gpr_we),
        .gpr_wi    (x_gpr_wi),
        .gpr_wd    (x_gpr_wd),
        .fpr_we    (x_fpr_we),
        .fpr_wi    (x_fpr_wi),
        .fpr_wd    (x_fpr_wd),
        .done      (done),
        .flags     (fl)
    );

    assign executed       = fl.executed;
    assign flag_undef     = fl.undef;
    assign flag_unpred_rt = fl.unpred_rt;
    assign flag_cu        = fl.cu;
    assign flag_sbz       = fl.sbz;
    assign flag_nomatch   = fl.nomatch;
endmodule

// File: rtl/hpx_xfer_chk.sv
module hpx_xfer_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic        done,
    input logic        executed,
    input logic        flag_undef,
    input logic        flag_unpred_rt,
    input logic        flag_nomatch,
    input logic        gpr_we,
    input logic [15:0] gpr_wd_hi,
    input logic        fpr_we,
    input logic [15:0] fpr_wd_hi
);
    // R10
    strobe_to_done_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> ##2 done);

    // R10
    done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(instr_valid, 2));

    // R10
    write_reports_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (gpr_we || fpr_we) |-> ##2 (done && executed));

    // R3
    gpr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_wd_hi == 16'h0000));

    // R3
    fpr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fpr_we |-> (fpr_wd_hi == 16'h0000));

    // R2
    one_dest_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gpr_we, fpr_we}));

    // R4
    undef_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_undef) |-> !executed);

    // R5
    rt15_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_unpred_rt) |-> !executed);

    // R1
    nomatch_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (done && flag_nomatch) |-> !executed);
endmodule

bind hp_xfer_unit hpx_xfer_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .instr_valid    (instr_valid),
    .done           (done),
    .executed       (executed),
    .flag_undef     (flag_undef),
    .flag_unpred_rt (flag_unpred_rt),
    .flag_nomatch   (flag_nomatch),
    .gpr_we         (x_gpr_we),
    .gpr_wd_hi      (x_gpr_wd[31:16]),
    .fpr_we         (x_fpr_we),
    .fpr_wd_hi      (x_fpr_wd[31:16])
);

// File: tb/hp_xfer_unit_test.sv
`timescale 1ns/1ps
module hp_xfer_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        enc_sel = 1'b0, cond_pass = 1'b1, fp16_en = 1'b1, fp_en = 1'b1, in_it = 1'b0;
    logic        gpr_ld_en = 1'b0;
    logic [3:0]  gpr_ld_idx = '0;
    logic [31:0] gpr_ld_data = '0;
    logic        fpr_ld_en = 1'b0;
    logic [4:0]  fpr_ld_idx = '0;
    logic [31:0] fpr_ld_data = '0;
    logic [3:0]  gpr_pk_idx = '0;
    logic [31:0] gpr_pk_data;
    logic [4:0]  fpr_pk_idx = '0;
    logic [31:0] fpr_pk_data;
    logic        done, executed, flag_undef, flag_unpred_rt, flag_cu, flag_sbz, flag_nomatch;

    always #4 clk = ~clk;

    hp_xfer_unit uut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] gpr_m [16];
    logic [31:0] fpr_m [32];

    typedef struct {
        logic [5:0]  flags;
        bit          to_gpr;
        logic [4:0]  idx;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sbq [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] top, input logic op, input logic [3:0] vn,
                                       input logic [3:0] rt, input logic n, input logic [5:0] sbz);
        return {top, 4'hE, 3'b000, op, vn, rt, 4'h9, n, sbz[5:4], 1'b1, sbz[3:0]};
    endfunction

    task automatic seed_gpr(input logic [3:0] i, input logic [31:0] v);
        @(negedge clk);
        gpr_ld_en = 1'b1; gpr_ld_idx = i; gpr_ld_data = v;
        @(negedge clk);
        gpr_ld_en = 1'b0;
        gpr_m[i] = v;
    endtask

    task automatic seed_fpr(input logic [4:0] i, input logic [31:0] v);
        @(negedge clk);
        fpr_ld_en = 1'b1; fpr_ld_idx = i; fpr_ld_data = v;
        @(negedge clk);
        fpr_ld_en = 1'b0;
        fpr_m[i] = v;
    endtask

    // Driver: expected values follow R1..R9 with the default CU_POLICY (nop, R7).
    task automatic send(input logic [31:0] w, input bit enc, input bit cp, input bit f16,
                        input bit fen, input bit it, input string req);
        exp_t e;
        logic [3:0] top = w[31:28];
        bit body = (w[27:21] == 7'b1110000) && (w[11:8] == 4'h9) && w[4];
        bit m    = body && (enc ? (top == 4'hE) : (top != 4'hF));
        bit op   = w[20];
        logic [3:0] rt = w[15:12];
        logic [4:0] fi = {w[19:16], w[7]};
        bit cu   = enc ? it : (top != 4'hE);
        bit und  = !f16;
        bit pass = cu ? 1'b0 : cp;
        bit sbz  = (w[6:5] != 0) || (w[3:0] != 0);
        bit ex   = m && !und && (rt != 4'hF) && pass && fen;
        if (ex) begin
            if (op) gpr_m[rt] = {16'h0, fpr_m[fi][15:0]};
            else    fpr_m[fi] = {16'h0, gpr_m[rt][15:0]};
        end
        e.flags  = m ? {1'b0, und, rt == 4'hF, cu, sbz, ex} : 6'b100000;
        e.to_gpr = op;
        e.idx    = op ? {1'b0, rt} : fi;
        e.val    = op ? gpr_m[rt] : fpr_m[fi];
        e.req    = req;
        sbq.push_back(e);
        @(negedge clk);
        instr_word = w; enc_sel = enc; cond_pass = cp; fp16_en = f16; fp_en = fen; in_it = it;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: result due on the falling edge after the edge that follows the write (R10).
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10 spurious done", 32'(done), 32'h0);
            end else begin
                exp_t e;
                logic [5:0] got;
                logic [31:0] v;
                e = sbq.pop_front();
                got = {flag_nomatch, flag_undef, flag_unpred_rt, flag_cu, flag_sbz, executed};
                chk(got == e.flags, {e.req, " flags"}, 32'(got), 32'(e.flags));
                if (e.to_gpr) gpr_pk_idx = e.idx[3:0];
                else          fpr_pk_idx = e.idx;
                #1;
                v = e.to_gpr ? gpr_pk_data : fpr_pk_data;
                chk(v == e.val, {e.req, " dest"}, v, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) gpr_m[i] = '0;
        for (int i = 0; i < 32; i++) fpr_m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        gpr_pk_idx = 4'd7; fpr_pk_idx = 5'd31;
        #1;
        chk(done == 1'b0, "R11 done", 32'(done), 32'h0);
        chk({flag_nomatch, flag_undef, flag_unpred_rt, flag_cu, flag_sbz, executed} == 6'b0,
            "R11 flags", 32'({flag_nomatch, flag_undef, flag_unpred_rt, flag_cu, flag_sbz, executed}), 32'h0);
        chk(gpr_pk_data == 32'h0, "R11 gpr", gpr_pk_data, 32'h0);
        chk(fpr_pk_data == 32'h0, "R11 fpr", fpr_pk_data, 32'h0);

        // R12 seed and peek
        seed_gpr(4'd3, 32'hDEADBEEF);
        seed_fpr(5'd6, 32'h12345678);
        seed_fpr(5'd31, 32'hCAFEF00D);
        seed_gpr(4'd9, 32'hFFFF8001);
        gpr_pk_idx = 4'd3; fpr_pk_idx = 5'd6;
        #1;
        chk(gpr_pk_data == 32'hDEADBEEF, "R12 gpr seed", gpr_pk_data, 32'hDEADBEEF);
        chk(fpr_pk_data == 32'h12345678, "R12 fpr seed", fpr_pk_data, 32'h12345678);

        // R2 R3 gpr->fpr, index {vn,n}=21, conditional encoding
        send(mk(4'hE, 1'b0, 4'hA, 4'd3, 1'b1, 6'h0), 1'b0, 1, 1, 1, 0, "R2 R3 gpr to fpr");
        // R2 R5 fpr->gpr into index 13, fixed encoding
        send(mk(4'hE, 1'b1, 4'h3, 4'd13, 1'b0, 6'h0), 1'b1, 1, 1, 1, 0, "R2 R5 fpr to gpr13");
        // R2 bit 7 is LSB: idx 1 vs idx 0
        send(mk(4'hE, 1'b0, 4'h0, 4'd9, 1'b1, 6'h0), 1'b0, 1, 1, 1, 0, "R2 n lsb idx1");
        send(mk(4'hE, 1'b0, 4'h0, 4'd3, 1'b0, 6'h0), 1'b0, 1, 1, 1, 0, "R2 idx0");
        // R3 top index 31 back to gpr, upper half cleared
        send(mk(4'hE, 1'b1, 4'hF, 4'd9, 1'b1, 6'h0), 1'b1, 1, 1, 1, 0, "R3 fpr31 to gpr");
        // R4
        send(mk(4'hE, 1'b1, 4'h3, 4'd3, 1'b0, 6'h0), 1'b0, 1, 0, 1, 0, "R4 fp16 off");
        // R5
        send(mk(4'hE, 1'b1, 4'h3, 4'd15, 1'b0, 6'h0), 1'b0, 1, 1, 1, 0, "R5 rt15");
        // R6 R7 conditional encoding, cond != 1110
        send(mk(4'h0, 1'b0, 4'h2, 4'd3, 1'b0, 6'h0), 1'b0, 1, 1, 1, 0, "R6 R7 cond field");
        // R6 R7 fixed encoding inside IT
        send(mk(4'hE, 1'b0, 4'h2, 4'd3, 1'b1, 6'h0), 1'b1, 1, 1, 1, 1, "R6 R7 in it");
        // R8
        send(mk(4'hE, 1'b0, 4'h4, 4'd3, 1'b0, 6'h0), 1'b0, 0, 1, 1, 0, "R8 cond fail");
        send(mk(4'hE, 1'b0, 4'h4, 4'd3, 1'b0, 6'h0), 1'b1, 1, 1, 0, 0, "R8 fp off");
        // R9
        send(mk(4'hE, 1'b0, 4'h5, 4'd3, 1'b0, 6'h2A), 1'b0, 1, 1, 1, 0, "R9 sbz set");
        // R1
        send(mk(4'hF, 1'b0, 4'h6, 4'd3, 1'b0, 6'h0), 1'b0, 1, 1, 1, 0, "R1 cond 1111");
        send(mk(4'h0, 1'b0, 4'h6, 4'd3, 1'b0, 6'h0), 1'b1, 1, 1, 1, 0, "R1 fixed top");
        send(mk(4'hE, 1'b0, 4'h6, 4'd3, 1'b0, 6'h0) ^ 32'h0000_0100, 1'b0, 1, 1, 1, 0, "R1 bits11to8");
        send(mk(4'hE, 1'b0, 4'h6, 4'd3, 1'b0, 6'h0) ^ 32'h0000_0010, 1'b0, 1, 1, 1, 0, "R1 bit4");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R10 all results", 32'(sbq.size()), 32'h0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule